// File: doc/BRIEF.md
# Hall-Sensor Six-Step Commutator

This block turns three digital Hall sensor levels from a three-phase brushless motor into six gate-drive enables, one high-side and one low-side enable per phase leg, for an external bridge predriver. A fixed six-step table picks the active high-side and low-side pair. A direction input runs the motor backwards by decoding the complemented Hall code through the same table.

An active-low PWM gate chops only the high-side enables. The low-side enable stays on for the whole commutation step. Two protection inputs also force the high side off: one from a supply under-voltage monitor and one from the off phase of a lock (stalled-rotor) protector. If all three Hall levels are equal, the code is invalid and every output is blanked.

The Hall levels pass through a synchronizer inside the block. All outputs are registered and reset synchronously.

Top module: `hall_commutator`

## Requirements
- R1: With `dir_rev` low, the synchronized Hall code {hall_in[2],hall_in[1],hall_in[0]} selects the enables as follows: 101 gives high V + low U, 100 gives high W + low U, 110 gives high W + low V, 010 gives high U + low V, 011 gives high U + low W, 001 gives high V + low W. Bit 0 of `hi_en`/`lo_en` is phase U, bit 1 is V and bit 2 is W.
- R2: With `dir_rev` high, the bitwise complement of the Hall code is decoded through the R1 table. For example, 010 gives high V + low U.
- R3: A Hall code of 000 or 111 drives all six enables low, in either direction.
- R4: While `pwm_n` is high, all high-side enables are low and the low-side enable is unchanged. While `pwm_n` is low, the high-side enable from the table is driven.
- R5: While `uv_fault` is high, all high-side enables are low and the low-side enable is unchanged.
- R6: While `lock_off` is high, all high-side enables are low and the low-side enable is unchanged.
- R7: A high `rst` sampled at a rising clock edge clears all six enables at that edge.
- R8: A Hall input change reaches the outputs at the third rising edge after it is applied (two synchronizer stages plus the output register). A change on `dir_rev`, `pwm_n`, `uv_fault` or `lock_off` reaches the outputs at the first rising edge.
- R9: At every cycle, at most one high-side and at most one low-side enable is set, and they never belong to the same phase leg.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| hall_in | input | 3 | Digital Hall levels, bit 2 first sensor, bit 0 third sensor |
| dir_rev | input | 1 | Direction select, high = reverse |
| pwm_n | input | 1 | PWM gate, low = drive on, high = high side off |
| uv_fault | input | 1 | Under-voltage shutdown of the high side |
| lock_off | input | 1 | Lock-protection off phase, forces the high side off |
| hi_en | output | 3 | High-side enables {W,V,U} |
| lo_en | output | 3 | Low-side enables {W,V,U} |

## Verification
The hardest case to reach is the moment when a Hall edge and a control change land in the same window. Hall changes take three edges to reach the outputs, while the control inputs take one. During that window the outputs still show the old step under the new gating. The stimulus changes the Hall code and then samples edge by edge, checking that the old pair holds for two edges and the new pair shows at the third. It also toggles the PWM gate and the protection inputs in the middle of a step, so the low-side enable can be seen holding while only the high side drops.

// File: rtl/hallcom_pkg.sv
package hallcom_pkg;
    localparam int PHASES = 3;

    typedef logic [PHASES-1:0] leg_t;

    typedef struct packed {
        leg_t hi;
        leg_t lo;
    } drive_t;

    localparam leg_t LEG_U = 3'b001;
    localparam leg_t LEG_V = 3'b010;
    localparam leg_t LEG_W = 3'b100;
    localparam leg_t LEG_NONE = 3'b000;
endpackage

// File: rtl/hall_sync.sv
module hall_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [WIDTH-1:0] stage_d;
        if (s == 0) begin : g_first
            always_comb stage_d = rst ? '0 : async_in;
        end else begin : g_next
            always_comb stage_d = rst ? '0 : stage_q[s-1];
        end
        always_ff @(posedge clk) begin
            stage_q[s] <= stage_d;
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/step_decoder.sv
module step_decoder
    import hallcom_pkg::*;
(
    input  logic [PHASES-1:0] hall_code,
    input  logic              reverse,
    output drive_t            step
);
    logic [PHASES-1:0] code;

    always_comb begin
        code = reverse ? ~hall_code : hall_code;
        step = '{hi: LEG_NONE, lo: LEG_NONE};
        unique case (code)
            3'b101:  step = '{hi: LEG_V, lo: LEG_U};
            3'b100:  step = '{hi: LEG_W, lo: LEG_U};
            3'b110:  step = '{hi: LEG_W, lo: LEG_V};
            3'b010:  step = '{hi: LEG_U, lo: LEG_V};
            3'b011:  step = '{hi: LEG_U, lo: LEG_W};
            3'b001:  step = '{hi: LEG_V, lo: LEG_W};
            default: step = '{hi: LEG_NONE, lo: LEG_NONE};
        endcase
    end
endmodule

// File: rtl/drive_gate.sv
module drive_gate
    import hallcom_pkg::*;
(
    input  drive_t step,
    input  logic   pwm_n,
    input  logic   uv_fault,
    input  logic   lock_off,
    output drive_t gated
);
    logic hi_block;

    always_comb begin
        hi_block = pwm_n | uv_fault | lock_off;
        gated.lo = step.lo;
        gated.hi = hi_block ? LEG_NONE : step.hi;
    end
endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
    import hallcom_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] hall_in,
    input  logic       dir_rev,
    input  logic       pwm_n,
    input  logic       uv_fault,
    input  logic       lock_off,
    output logic [2:0] hi_en,
    output logic [2:0] lo_en
);
    logic [PHASES-1:0] hall_s;
    drive_t            step;
    drive_t            gated;
    drive_t            out_d;
    drive_t            out_q;

    hall_sync #(
        .WIDTH  (PHASES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (hall_in),
        .sync_out (hall_s)
    );

    step_decoder u_dec (
        .hall_code (hall_s),
        .reverse   (dir_rev),
        .step      (step)
    );

    drive_gate u_gate (
        .step     (step),
        .pwm_n    (pwm_n),
        .uv_fault (uv_fault),
        .lock_off (lock_off),
        .gated    (gated)
    );

    always_comb begin
        out_d = rst ? '{hi: LEG_NONE, lo: LEG_NONE} : gated;
    end

    always_ff @(posedge clk) begin
        out_q <= out_d;
    end

    assign hi_en = out_q.hi;
    assign lo_en = out_q.lo;
endmodule

// File: rtl/hall_commutator_chk.sv
module hall_commutator_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] hall_s,
    input logic       pwm_n,
    input logic       uv_fault,
    input logic       lock_off,
    input logic [2:0] hi_en,
    input logic [2:0] lo_en
);
    a_r7_reset_clears: assert property (@(posedge clk)
        rst |=> (hi_en == 3'b000 && lo_en == 3'b000));

    a_r9_leg_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hi_en) && $onehot0(lo_en) && ((hi_en & lo_en) == 3'b000));

    a_r4_pwm_gates_high: assert property (@(posedge clk) disable iff (rst)
        pwm_n |=> (hi_en == 3'b000));

    a_r5_undervolt_high_off: assert property (@(posedge clk) disable iff (rst)
        uv_fault |=> (hi_en == 3'b000));

    a_r6_lock_high_off: assert property (@(posedge clk) disable iff (rst)
        lock_off |=> (hi_en == 3'b000));

    a_r3_equal_code_blank: assert property (@(posedge clk) disable iff (rst)
        (hall_s == 3'b000 || hall_s == 3'b111) |=> (hi_en == 3'b000 && lo_en == 3'b000));
endmodule

bind hall_commutator hall_commutator_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .hall_s   (hall_s),
    .pwm_n    (pwm_n),
    .uv_fault (uv_fault),
    .lock_off (lock_off),
    .hi_en    (hi_en),
    .lo_en    (lo_en)
);

// File: tb/hall_commutator_tb.sv
module hall_commutator_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] hall_in = 3'b101;
    logic       dir_rev = 1'b0;
    logic       pwm_n = 1'b0;
    logic       uv_fault = 1'b0;
    logic       lock_off = 1'b0;
    logic [2:0] hi_en;
    logic [2:0] lo_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [2:0] hi;
        logic [2:0] lo;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    always #5 clk = ~clk;

    hall_commutator u_dut (
        .clk      (clk),
        .rst      (rst),
        .hall_in  (hall_in),
        .dir_rev  (dir_rev),
        .pwm_n    (pwm_n),
        .uv_fault (uv_fault),
        .lock_off (lock_off),
        .hi_en    (hi_en),
        .lo_en    (lo_en)
    );

    task automatic check(input logic [2:0] eh, input logic [2:0] el, input string tag);
        n_checks++;
        if (hi_en !== eh || lo_en !== el) begin
            n_fail++;
            $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b", tag, hi_en, lo_en, eh, el);
        end
    endtask

    // Independent reference for the forward table (R1); reverse is R2.
    function automatic void ref_step(input logic [2:0] h, input logic rev,
                                     output logic [2:0] eh, output logic [2:0] el);
        logic [2:0] c;
        c = rev ? ~h : h;
        case (c)
            3'b101: begin eh = 3'b010; el = 3'b001; end
            3'b100: begin eh = 3'b100; el = 3'b001; end
            3'b110: begin eh = 3'b100; el = 3'b010; end
            3'b010: begin eh = 3'b001; el = 3'b010; end
            3'b011: begin eh = 3'b001; el = 3'b100; end
            3'b001: begin eh = 3'b010; el = 3'b100; end
            default: begin eh = 3'b000; el = 3'b000; end
        endcase
    endfunction

    // Driver: apply a full input set, let it settle, queue the expected result.
    task automatic apply(input logic [2:0] h, input logic rev, input logic pn,
                         input logic uv, input logic lk, input string tag);
        logic [2:0] eh;
        logic [2:0] el;
        exp_t e;
        @(negedge clk);
        hall_in = h; dir_rev = rev; pwm_n = pn; uv_fault = uv; lock_off = lk;
        repeat (4) @(negedge clk);
        ref_step(h, rev, eh, el);
        if (pn || uv || lk) eh = 3'b000;
        e.hi = eh; e.lo = el; e.tag = tag;
        sb_q.push_back(e);
        @(posedge clk);
        #3;
    endtask

    // Monitor: pops expectations and compares away from the edge.
    always begin
        @(posedge clk);
        #2;
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(e.hi, e.lo, e.tag);
        end
    end

    // R9 every cycle
    always begin
        @(posedge clk);
        #2;
        if (!rst && !finished) begin
            n_checks++;
            if ($countones(hi_en) > 1 || $countones(lo_en) > 1 || (hi_en & lo_en) != 3'b000) begin
                n_fail++;
                $display("FAIL R9: hi=%b lo=%b expected one-hot legs, disjoint", hi_en, lo_en);
            end
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R7: reset with drive inputs active
        repeat (4) @(posedge clk);
        #2;
        check(3'b000, 3'b000, "R7 reset state");
        @(negedge clk);
        rst = 1'b0;

        // R1: forward table, all six codes
        apply(3'b101, 1'b0, 1'b0, 1'b0, 1'b0, "R1 fwd 101");
        apply(3'b100, 1'b0, 1'b0, 1'b0, 1'b0, "R1 fwd 100");
        apply(3'b110, 1'b0, 1'b0, 1'b0, 1'b0, "R1 fwd 110");
        apply(3'b010, 1'b0, 1'b0, 1'b0, 1'b0, "R1 fwd 010");
        apply(3'b011, 1'b0, 1'b0, 1'b0, 1'b0, "R1 fwd 011");
        apply(3'b001, 1'b0, 1'b0, 1'b0, 1'b0, "R1 fwd 001");

        // R2: reverse direction, all six codes
        apply(3'b010, 1'b1, 1'b0, 1'b0, 1'b0, "R2 rev 010");
        apply(3'b011, 1'b1, 1'b0, 1'b0, 1'b0, "R2 rev 011");
        apply(3'b001, 1'b1, 1'b0, 1'b0, 1'b0, "R2 rev 001");
        apply(3'b101, 1'b1, 1'b0, 1'b0, 1'b0, "R2 rev 101");
        apply(3'b100, 1'b1, 1'b0, 1'b0, 1'b0, "R2 rev 100");
        apply(3'b110, 1'b1, 1'b0, 1'b0, 1'b0, "R2 rev 110");

        // R3: invalid codes in both directions
        apply(3'b000, 1'b0, 1'b0, 1'b0, 1'b0, "R3 fwd 000");
        apply(3'b111, 1'b0, 1'b0, 1'b0, 1'b0, "R3 fwd 111");
        apply(3'b000, 1'b1, 1'b0, 1'b0, 1'b0, "R3 rev 000");
        apply(3'b111, 1'b1, 1'b0, 1'b0, 1'b0, "R3 rev 111");

        // R4/R5/R6: high side forced off, low side held
        apply(3'b110, 1'b0, 1'b1, 1'b0, 1'b0, "R4 pwm_n high");
        apply(3'b110, 1'b0, 1'b0, 1'b1, 1'b0, "R5 undervoltage");
        apply(3'b011, 1'b1, 1'b0, 1'b0, 1'b1, "R6 lock off");
        apply(3'b011, 1'b1, 1'b0, 1'b0, 1'b0, "R6 lock released");

        // R8: Hall latency, forward 101 -> 100
        apply(3'b101, 1'b0, 1'b0, 1'b0, 1'b0, "R8 settle 101");
        @(negedge clk);
        hall_in = 3'b100;
        @(posedge clk); #2; check(3'b010, 3'b001, "R8 edge1 old step");
        @(posedge clk); #2; check(3'b010, 3'b001, "R8 edge2 old step");
        @(posedge clk); #2; check(3'b100, 3'b001, "R8 edge3 new step");

        // R4/R8: PWM chopping mid-step takes one edge, low side steady
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            pwm_n = ~pwm_n;
            @(posedge clk); #2;
            check(pwm_n ? 3'b000 : 3'b100, 3'b001, "R4 chop one edge");
        end

        // R5/R8 and R6/R8: protection acts at the next edge
        @(negedge clk); uv_fault = 1'b1;
        @(posedge clk); #2; check(3'b000, 3'b001, "R5 next edge");
        @(negedge clk); uv_fault = 1'b0; lock_off = 1'b1;
        @(posedge clk); #2; check(3'b000, 3'b001, "R6 next edge");
        @(negedge clk); lock_off = 1'b0;
        @(posedge clk); #2; check(3'b100, 3'b001, "R8 release next edge");

        // R8: direction change takes one edge (synced code 100 reverse -> 011 fwd)
        @(negedge clk); dir_rev = 1'b1;
        @(posedge clk); #2; check(3'b001, 3'b100, "R8 dir one edge");

        // R7: reset in the middle of driving
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #2; check(3'b000, 3'b000, "R7 mid-run reset");
        @(negedge clk); rst = 1'b0;
        repeat (4) @(negedge clk);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule